// File: doc/BRIEF.md
# Gated Frequency and Period Counter

This block measures a signal in one of two ways. In frequency mode it counts the rising edges of one of two inputs while a gate window is open: `hiIn` is the fast input and `loIn` is the slow one. In period mode it counts system clock cycles, which serve as the reference, between the first and the last rising edge of `loIn` inside the gate. Both inputs are asynchronous. Each one passes through a synchronizer and an edge detector before it reaches the counter. Counts stop at the all-ones value instead of wrapping.

Software first issues a setup command that picks the mode. It then issues a start command that picks a gate of 1, 4, 8 or 32 base ticks. One base tick is `TICK_DIV` clock cycles, which is 1 ms at the default clock. `busy` stays high while the gate is open. When the gate closes, `done` rises and `result` holds the final count until the next start.

Top module: `fpc_top`

## Requirements
- R1: After reset, `result` is 0, `busy` is 0 and `done` is 0. The mode is frequency counting on `hiIn`, so a measurement started with no setup counts `hiIn` edges.
- R2: A setup command (`setupValid` high while idle) loads `setupMode`. The codes are: 2'b00 counts frequency on `hiIn`, 2'b01 counts frequency on `loIn`, and 2'b10 measures period on `loIn`. Code 2'b11 leaves the current mode unchanged.
- R3: A start command (`startValid` high while idle) opens a gate whose length is set by `gateSel`. The codes are 2'b00 = 1, 2'b01 = 4, 2'b10 = 8 and 2'b11 = 32 base ticks of `TICK_DIV` cycles each. `busy` is high for exactly ticks × `TICK_DIV` cycles after the accepting edge.
- R4: `done` rises on the same edge on which `busy` falls. `done` and `result` then hold until the next start.
- R5: An accepted start clears `result` and `done` on the accepting edge.
- R6: In frequency mode, `result` equals the number of rising edges on the selected input inside the gate. Edges on the other input have no effect.
- R7: In period mode, `result` equals the number of clock cycles from the first to the last `loIn` rising edge inside the gate. The result is 0 when fewer than two edges occur. `hiIn` has no effect.
- R8: Counting saturates at 2^`CNT_W` − 1, in both modes.
- R9: While `busy` is high, start and setup commands are ignored. The gate length and the mode do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock and period reference |
| rstN | input | 1 | Active-low synchronous reset |
| hiIn | input | 1 | Fast measurement input, asynchronous |
| loIn | input | 1 | Slow measurement input, asynchronous |
| setupValid | input | 1 | Setup command strobe |
| setupMode | input | 2 | Mode code for the setup command |
| startValid | input | 1 | Start command strobe |
| gateSel | input | 2 | Gate length code for the start command |
| result | output | CNT_W (20) | Measured count |
| busy | output | 1 | Gate open |
| done | output | 1 | Measurement finished |

## Verification
An edge on an input pin reaches the counter on the third rising clock edge after it occurs: two edges for the synchronizer and one for the count register. The clear from a start is visible one cycle after the command. `busy` falls and `done` rises exactly ticks × `TICK_DIV` cycles after the accepting edge. The bench therefore drives every stimulus edge at least eight cycles after the start and about twenty cycles before the gate closes. It samples all outputs on falling clock edges and measures the `busy` length by counting those falling edges.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    MODE_FREQ_HI   = 2'b00,
    MODE_FREQ_LO   = 2'b01,
    MODE_PERIOD_LO = 2'b10,
    MODE_RESERVED  = 2'b11
  } measMode_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic clr;
    logic run;
    logic periodMode;
    logic useLow;
  } strb_t;

  localparam int GATE_TICK_W = 6;

  function automatic logic [GATE_TICK_W-1:0] gateTicks(input logic [1:0] sel);
    case (sel)
      2'b00:   gateTicks = GATE_TICK_W'(1);
      2'b01:   gateTicks = GATE_TICK_W'(4);
      2'b10:   gateTicks = GATE_TICK_W'(8);
      default: gateTicks = GATE_TICK_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/fpc_edge_sync.sv
module fpc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] shQ;
  logic              prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shQ   <= '0;
      prevQ <= 1'b0;
    end else begin
      shQ   <= {shQ[STAGES-2:0], din};
      prevQ <= shQ[STAGES-1];
    end
  end

  assign rise = shQ[STAGES-1] & ~prevQ;

  // R6: one input edge yields one single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rise |=> !rise);

endmodule

// File: rtl/fpc_ctrl.sv
module fpc_ctrl
  import fpc_pkg::*;
#(
  parameter int TICK_DIV = 200000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       setupValid,
  input  logic [1:0] setupMode,
  input  logic       startValid,
  input  logic [1:0] gateSel,
  output strb_t      strb,
  output logic       busy,
  output logic       done
);
  localparam int PRE_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int TICK_W = GATE_TICK_W;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  measMode_e         modeQ;
  logic              busyQ, doneQ;
  logic [PRE_W-1:0]  preQ;
  logic [TICK_W-1:0] tickQ, gateQ;
  logic              accept, tickEnd;

  assign accept  = startValid && !busyQ;
  assign tickEnd = (preQ == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_FREQ_HI;
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      preQ  <= '0;
      tickQ <= '0;
      gateQ <= '0;
    end else begin
      if (!busyQ && setupValid && setupMode != MODE_RESERVED)
        modeQ <= measMode_e'(setupMode);
      if (accept) begin
        busyQ <= 1'b1;
        doneQ <= 1'b0;
        preQ  <= '0;
        tickQ <= '0;
        gateQ <= gateTicks(gateSel);
      end else if (busyQ) begin
        if (tickEnd) begin
          preQ <= '0;
          if (tickQ == gateQ - 1'b1) begin
            busyQ <= 1'b0;
            doneQ <= 1'b1;
          end else begin
            tickQ <= tickQ + 1'b1;
          end
        end else begin
          preQ <= preQ + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.clr        = accept;
    strb.run        = busyQ;
    strb.periodMode = (modeQ == MODE_PERIOD_LO);
    strb.useLow     = (modeQ != MODE_FREQ_HI);
  end

  assign busy = busyQ;
  assign done = doneQ;

  a_r4_busy_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busyQ && doneQ));
  a_r4_end_sets_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> doneQ);
  a_r5_start_arms: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !busyQ) |=> (busyQ && !doneQ));
  a_r2_reserved_kept: assert property (@(posedge clk) disable iff (!rstN)
    (setupValid && setupMode == 2'b11) |=> $stable(modeQ));
  a_r9_setup_busy_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (setupValid && busyQ) |=> $stable(modeQ));
  a_r9_gate_kept: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && $past(busyQ)) |-> $stable(gateQ));
  a_r3_tick_bound: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (tickQ < gateQ));

endmodule

// File: rtl/fpc_dpath.sv
module fpc_dpath
  import fpc_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  strb_t            strb,
  input  logic             riseHi,
  input  logic             riseLo,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cntQ, accQ, cntInc, accInc;
  logic             armedQ, edgeSel;

  assign edgeSel = strb.useLow ? riseLo : riseHi;
  assign cntInc  = (cntQ == MAXV) ? MAXV : cntQ + 1'b1;
  assign accInc  = (accQ == MAXV) ? MAXV : accQ + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= '0;
      accQ   <= '0;
      armedQ <= 1'b0;
    end else if (strb.clr) begin
      cntQ   <= '0;
      accQ   <= '0;
      armedQ <= 1'b0;
    end else if (strb.run) begin
      if (strb.periodMode) begin
        if (edgeSel && !armedQ) begin
          armedQ <= 1'b1;
          accQ   <= '0;
        end else if (armedQ) begin
          accQ <= accInc;
          if (edgeSel) cntQ <= accInc;
        end
      end else if (edgeSel) begin
        cntQ <= cntInc;
      end
    end
  end

  assign count = cntQ;

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.clr && cntQ == MAXV) |=> (cntQ == MAXV));
  a_r5_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (cntQ == '0));
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.clr) |=> $stable(cntQ));
  a_r6_unit_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.periodMode) |=>
      ((cntQ == $past(cntQ)) || (cntQ == CNT_W'($past(cntQ) + 1'b1))));

endmodule

// File: rtl/fpc_top.sv
module fpc_top
  import fpc_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int TICK_DIV    = 200000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hiIn,
  input  logic             loIn,
  input  logic             setupValid,
  input  logic [1:0]       setupMode,
  input  logic             startValid,
  input  logic [1:0]       gateSel,
  output logic [CNT_W-1:0] result,
  output logic             busy,
  output logic             done
);
  localparam int N_IN = 2;

  strb_t           strb;
  logic [N_IN-1:0] rawIn, riseVec;

  assign rawIn = {loIn, hiIn};

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    fpc_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk (clk),
      .rstN(rstN),
      .din (rawIn[g]),
      .rise(riseVec[g])
    );
  end

  fpc_ctrl #(.TICK_DIV(TICK_DIV)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .setupValid(setupValid),
    .setupMode (setupMode),
    .startValid(startValid),
    .gateSel   (gateSel),
    .strb      (strb),
    .busy      (busy),
    .done      (done)
  );

  fpc_dpath #(.CNT_W(CNT_W)) dpath_i (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .riseHi(riseVec[0]),
    .riseLo(riseVec[1]),
    .count (result)
  );

endmodule

// File: tb/fpc_top_tb_top.sv
`timescale 1ns/1ps
module fpc_top_tb_top;
  localparam int DIV_A = 40;
  localparam int DIV_S = 50;
  localparam int W_A   = 20;
  localparam int W_S   = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic hiIn = 1'b0, loIn = 1'b0;
  logic aSetup = 0, aStart = 0, sSetup = 0, sStart = 0;
  logic [1:0] aMode = 0, aGate = 0, sMode = 0, sGate = 0;
  logic [W_A-1:0] aRes;
  logic [W_S-1:0] sRes;
  logic aBusy, aDone, sBusy, sDone;

  fpc_top #(.CNT_W(W_A), .TICK_DIV(DIV_A)) dut_i (
    .clk(clk), .rstN(rstN), .hiIn(hiIn), .loIn(loIn),
    .setupValid(aSetup), .setupMode(aMode), .startValid(aStart), .gateSel(aGate),
    .result(aRes), .busy(aBusy), .done(aDone));

  fpc_top #(.CNT_W(W_S), .TICK_DIV(DIV_S)) sat_i (
    .clk(clk), .rstN(rstN), .hiIn(hiIn), .loIn(loIn),
    .setupValid(sSetup), .setupMode(sMode), .startValid(sStart), .gateSel(sGate),
    .result(sRes), .busy(sBusy), .done(sDone));

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  task automatic checkEq(string req, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  function automatic longint satW(longint v, int w);
    longint mx = (longint'(1) << w) - 1;
    return (v > mx) ? mx : v;
  endfunction

  function automatic int gateLen(int sel, int div);
    case (sel)
      0: return div;
      1: return 4 * div;
      2: return 8 * div;
      default: return 32 * div;
    endcase
  endfunction

  function automatic longint expResult(int mode, int k, int p, int w);
    if (mode == 2) return (k >= 2) ? satW(longint'(k - 1) * p, w) : 0;
    return satW(k, w);
  endfunction

  function automatic bit getBusy(int s);
    return s ? sBusy : aBusy;
  endfunction
  function automatic bit getDone(int s);
    return s ? sDone : aDone;
  endfunction
  function automatic longint getRes(int s);
    return s ? longint'(sRes) : longint'(aRes);
  endfunction

  task automatic setCtl(int s, bit sv, logic [1:0] sm, bit st, logic [1:0] gs);
    if (s) begin sSetup = sv; sMode = sm; sStart = st; sGate = gs; end
    else   begin aSetup = sv; aMode = sm; aStart = st; aGate = gs; end
  endtask

  task automatic driveHi(int k, int p);
    for (int i = 0; i < k; i++) begin
      hiIn = 1'b1; repeat (p / 2) @(negedge clk);
      hiIn = 1'b0; repeat (p - p / 2) @(negedge clk);
    end
  endtask
  task automatic driveLo(int k, int p);
    for (int i = 0; i < k; i++) begin
      loIn = 1'b1; repeat (p / 2) @(negedge clk);
      loIn = 1'b0; repeat (p - p / 2) @(negedge clk);
    end
  endtask

  task automatic doSetup(int s, logic [1:0] m);
    @(negedge clk);
    setCtl(s, 1'b1, m, 1'b0, 2'b00);
    @(negedge clk);
    setCtl(s, 1'b0, 2'b00, 1'b0, 2'b00);
  endtask

  task automatic runMeas(int s, int gsel, int kHi, int pHi, int kLo, int pLo,
                         bit disturb, longint exp, string req);
    int busyCnt = 0;
    longint held;
    @(negedge clk);
    setCtl(s, 1'b0, 2'b00, 1'b1, 2'(gsel));
    @(negedge clk);
    setCtl(s, 1'b0, 2'b00, 1'b0, 2'b00);
    checkEq("R5 clear result", getRes(s), 0);
    checkEq("R5 clear done", getDone(s), 0);
    fork
      begin
        while (getBusy(s) && busyCnt < 100000) begin
          busyCnt++;
          @(negedge clk);
        end
      end
      begin
        repeat (4) @(negedge clk);
        if (disturb) begin
          setCtl(s, 1'b1, 2'b01, 1'b1, 2'b11);
          @(negedge clk);
          setCtl(s, 1'b0, 2'b00, 1'b0, 2'b00);
        end
        repeat (4) @(negedge clk);
        fork
          driveHi(kHi, pHi);
          driveLo(kLo, pLo);
        join
      end
    join
    checkEq(disturb ? "R9 gate length kept" : "R3 gate length", busyCnt, gateLen(gsel, s ? DIV_S : DIV_A));
    checkEq("R4 done at gate end", getDone(s), 1);
    checkEq(req, getRes(s), exp);
    held = getRes(s);
    repeat (4) @(negedge clk);
    checkEq("R4 result held", getRes(s), held);
    checkEq("R4 done held", getDone(s), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seedInit;
    seedInit = $urandom(32'd4711);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkEq("R1 result after reset", aRes, 0);
    checkEq("R1 busy after reset", aBusy, 0);
    checkEq("R1 done after reset", aDone, 0);
    // R1 default mode counts hiIn; R6 loIn ignored
    runMeas(0, 1, 6, 6, 3, 10, 0, 6, "R1 default mode hiIn");
    // R2 mode 01, then reserved code keeps it
    doSetup(0, 2'b01);
    doSetup(0, 2'b11);
    runMeas(0, 1, 4, 8, 7, 6, 0, 7, "R2 reserved code keeps loIn mode");
    // R9 commands during busy ignored
    doSetup(0, 2'b00);
    runMeas(0, 1, 5, 6, 9, 4, 1, 5, "R9 start during busy ignored");
    runMeas(0, 1, 3, 8, 7, 6, 0, 3, "R9 setup during busy ignored");
    // R7 period with a single edge
    doSetup(0, 2'b10);
    runMeas(0, 1, 10, 6, 1, 20, 0, 0, "R7 single edge gives zero");
    runMeas(0, 2, 12, 5, 5, 37, 0, 4 * 37, "R7 period span hiIn ignored");
    // R8 saturation in both modes on the narrow instance
    doSetup(1, 2'b00);
    runMeas(1, 3, 300, 4, 0, 4, 0, 255, "R8 frequency saturation");
    doSetup(1, 2'b10);
    runMeas(1, 2, 0, 4, 4, 100, 0, 255, "R8 period saturation");
    // randomized measurements on the wide instance (R3 R6 R7)
    for (int it = 0; it < 12; it++) begin
      int mode, gsel, budget, pS, kS, pO, kO, kMax;
      mode = $urandom_range(0, 2);
      gsel = $urandom_range(0, 3);
      budget = gateLen(gsel, DIV_A) - 30;
      pS = $urandom_range(4, 12);
      kMax = budget / pS; if (kMax > 40) kMax = 40;
      kS = $urandom_range(0, kMax);
      pO = $urandom_range(4, 12);
      kMax = budget / pO; if (kMax > 40) kMax = 40;
      kO = $urandom_range(0, kMax);
      doSetup(0, 2'(mode));
      if (mode == 0)
        runMeas(0, gsel, kS, pS, kO, pO, 0, expResult(mode, kS, pS, W_A), "R6 random hiIn frequency");
      else
        runMeas(0, gsel, kO, pO, kS, pS, 0, expResult(mode, kS, pS, W_A),
                mode == 1 ? "R6 random loIn frequency" : "R7 random loIn period");
    end
    finished = 1;
    summary();
    $finish;
  end

endmodule